// File: doc/BRIEF.md
# SDRAM Command Monitor with Bank State Tracking

This block watches the command pins of a synchronous DRAM bus, one sample per rising clock. It turns each sample into a command code and follows the life of every internal bank through four states: closed, opening, open and closing. It also keeps the row that was last opened in each bank. Any command that breaks a timing rule or a sequencing rule raises a violation pulse. The block is meant to sit beside a memory controller as a protocol checker. It drives no pins of the memory and carries no data.

All timing rules are counted in clock cycles. Per-bank counters measure the time since an activate and the time left before a closing bank is closed again. A countdown also follows an access that closes its bank by itself once its burst is done. The burst length comes from the last accepted mode-register write. When the clock-enable pin was low on the previous cycle, decoding stops and every counter holds its value.

Top module: `sdmon_top`

## Requirements
- R1: After reset, `cmdCode` is 0, every bank reads closed (0), `openRow` is all zero and `violation` is zero.
- R2: Each command sampled at a rising edge appears on `cmdCode` and `violation` right after that edge. With `csN` high the code is 1 (deselect). Otherwise the pins {rasN,casN,weN} decode as follows: 111 gives 0 (no-op), 011 gives 2 (activate), 101 gives 3 (read), 100 gives 5 (write), 110 gives 7 (burst stop), 010 gives 8 (precharge), 001 gives 10 (refresh) and 000 gives 12 (mode write).
- R3: On a read or write, `addr[10]` high selects self-closing, and the code becomes 4 (read) or 6 (write). On a precharge, `addr[10]` high gives code 9 and closes every open bank whatever `ba` holds.
- R4: The value i on `ba` selects bank i. The state of bank i is `bankState[2i+1:2i]`, with 0 closed, 1 opening, 2 open and 3 closing. `openRow[ROW_W*i +: ROW_W]` holds the row of the last activate that bank i accepted.
- R5: An activate to a closed bank opens it and takes its row. The bank reads opening until T_RCD cycles after the activate. A read or write issued fewer than T_RCD cycles after the activate sets `violation[0]`.
- R6: A precharge issued fewer than T_RAS cycles after the activate of an opening or open bank sets `violation[0]`. The bank then reads closing, and an activate issued T_RP cycles after the precharge is accepted.
- R7: An activate to a bank that is not closed, or a read or write to a closed or closing bank, sets `violation[2]` and leaves that bank unchanged.
- R8: A self-closing access to an open bank arms a countdown. While it runs, a read or write to the same bank sets `violation[3]`; an access to another bank is legal. The bank starts closing BL cycles after the access and is closed T_RP cycles after that.
- R9: A mode write takes `addr[2:0]` as the burst code: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page; any other code gives 1. The write takes effect only when all banks are closed. The burst length after reset is 1.
- R10: A mode write, a refresh or a self-refresh entry (code 11) while any bank is not closed sets `violation[4]`.
- R11: A self-closing read or write while the burst code is full page sets `violation[5]`, and the access then does not close its bank.
- R12: Two activates to different banks fewer than T_RRD cycles apart set `violation[1]` on the second.
- R13: If `cke` was low at the previous edge, `cmdCode` is 13, no violation is raised and no bank state or counter changes. A refresh sampled with `cke` low is decoded as self-refresh entry, code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the pins are sampled on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock-enable pin of the memory |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ROW_W | Multiplexed address; bit 10 is the close/all flag and bits 2:0 the burst code |
| ba | input | 2 | Bank select |
| cmdCode | output | 4 | Decoded command code |
| bankState | output | 2*NUM_BANKS | State of each bank, two bits per bank |
| openRow | output | ROW_W*NUM_BANKS | Row last opened in each bank |
| violation | output | 6 | Violation pulses, one bit per rule |

## Verification
Every result is registered once. So `cmdCode`, `violation`, `bankState` and `openRow` show the effect of the command sampled at edge k right after edge k. The bench drives each command at a falling edge and reads the outputs at the next falling edge. Delayed effects are checked at the edges worked out from the rules. A bank reads open from edge a+T_RCD-1 after an activate at edge a. It reads closing T_RP-1 edges after a precharge, then closed. A self-closing access at edge k starts closing at edge k+BL. While `cke` is held low, the expected closing time moves out by one edge for every suppressed edge. The random phase tracks the `cke` value of the previous edge itself, so the suppressed code is expected on exactly those cycles.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

  localparam int BANK_W = 2;
  localparam int AP_BIT = 10;

  // violation vector bit positions
  localparam int V_TIME  = 0;
  localparam int V_RRD   = 1;
  localparam int V_SEQ   = 2;
  localparam int V_APHIT = 3;
  localparam int V_BUSY  = 4;
  localparam int V_FPAP  = 5;
  localparam int V_W     = 6;

  typedef enum logic [3:0] {
    CMD_NOP    = 4'd0,
    CMD_DESEL  = 4'd1,
    CMD_ACT    = 4'd2,
    CMD_RD     = 4'd3,
    CMD_RDA    = 4'd4,
    CMD_WR     = 4'd5,
    CMD_WRA    = 4'd6,
    CMD_BST    = 4'd7,
    CMD_PRE    = 4'd8,
    CMD_PREALL = 4'd9,
    CMD_REF    = 4'd10,
    CMD_SELF   = 4'd11,
    CMD_MRS    = 4'd12,
    CMD_HOLD   = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPENING = 2'd1,
    BK_OPEN    = 2'd2,
    BK_CLOSING = 2'd3
  } bank_e;

  // strobes from the decoder to the bank array
  typedef struct packed {
    logic              tick;      // decoding enabled this edge
    logic              act;
    logic              acc;       // read or write
    logic              apReq;     // self-closing access accepted
    logic              pre;
    logic              preAll;
    logic [BANK_W-1:0] bank;
    logic [3:0]        burstLen;
  } strobe_t;

endpackage

// File: rtl/sdmon_ctrl.sv
module sdmon_ctrl
  import sdmon_pkg::*;
#(
  parameter int T_RRD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              apBit,
  input  logic [2:0]        modeBits,
  input  logic [BANK_W-1:0] ba,
  input  logic              allIdle,
  output strobe_t           strobe,
  output cmd_e              cmdQ,
  output logic [V_W-1:0]    ctrlViol
);

  localparam int RRD_W = $clog2(T_RRD + 1);
  localparam logic [RRD_W-1:0] RRD_L = RRD_W'(T_RRD);

  logic              ckePrev;
  logic [2:0]        blCode;
  logic [RRD_W-1:0]  rrdAge;
  logic              actSeen;
  logic [BANK_W-1:0] lastBa;
  cmd_e              cmdNow;
  logic              fullPage;
  logic [3:0]        burstLen;
  logic              rrdHit, busyHit, fpHit, isAp;

  // command decode
  always_comb begin
    if (!ckePrev) begin
      cmdNow = CMD_HOLD;
    end else if (csN) begin
      cmdNow = CMD_DESEL;
    end else begin
      unique case ({rasN, casN, weN})
        3'b111:  cmdNow = CMD_NOP;
        3'b011:  cmdNow = CMD_ACT;
        3'b101:  cmdNow = apBit ? CMD_RDA : CMD_RD;
        3'b100:  cmdNow = apBit ? CMD_WRA : CMD_WR;
        3'b110:  cmdNow = CMD_BST;
        3'b010:  cmdNow = apBit ? CMD_PREALL : CMD_PRE;
        3'b001:  cmdNow = cke ? CMD_REF : CMD_SELF;
        default: cmdNow = CMD_MRS;
      endcase
    end
  end

  // burst length from the stored mode code
  always_comb begin
    fullPage = (blCode == 3'b111);
    unique case (blCode)
      3'b001:  burstLen = 4'd2;
      3'b010:  burstLen = 4'd4;
      3'b011:  burstLen = 4'd8;
      default: burstLen = 4'd1;
    endcase
  end

  assign isAp    = (cmdNow == CMD_RDA) || (cmdNow == CMD_WRA);
  assign rrdHit  = (cmdNow == CMD_ACT) && actSeen && (rrdAge < RRD_L) && (ba != lastBa);
  assign busyHit = ((cmdNow == CMD_MRS) || (cmdNow == CMD_REF) || (cmdNow == CMD_SELF)) && !allIdle;
  assign fpHit   = isAp && fullPage;

  always_comb begin
    strobe.tick     = ckePrev;
    strobe.act      = (cmdNow == CMD_ACT);
    strobe.acc      = (cmdNow == CMD_RD) || (cmdNow == CMD_WR) || isAp;
    strobe.apReq    = isAp && !fullPage;
    strobe.pre      = (cmdNow == CMD_PRE) || (cmdNow == CMD_PREALL);
    strobe.preAll   = (cmdNow == CMD_PREALL);
    strobe.bank     = ba;
    strobe.burstLen = burstLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckePrev  <= 1'b1;
      blCode   <= 3'b000;
      rrdAge   <= '0;
      actSeen  <= 1'b0;
      lastBa   <= '0;
      cmdQ     <= CMD_NOP;
      ctrlViol <= '0;
    end else begin
      ckePrev <= cke;
      cmdQ    <= cmdNow;
      ctrlViol         <= '0;
      ctrlViol[V_RRD]  <= rrdHit;
      ctrlViol[V_BUSY] <= busyHit;
      ctrlViol[V_FPAP] <= fpHit;
      if (cmdNow == CMD_MRS && allIdle) blCode <= modeBits;
      if (cmdNow == CMD_ACT) begin
        rrdAge  <= RRD_W'(1);
        actSeen <= 1'b1;
        lastBa  <= ba;
      end else if (ckePrev && rrdAge < RRD_L) begin
        rrdAge <= rrdAge + RRD_W'(1);
      end
    end
  end

  // R13: a low clock enable suppresses decoding of the following edge
  a_r13_hold_after_low: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> ##1 (cmdQ == CMD_HOLD));

  // R10: the busy flag only accompanies mode write or refresh commands
  a_r10_busy_cmd: assert property (@(posedge clk) disable iff (!rstN)
    ctrlViol[V_BUSY] |-> (cmdQ == CMD_MRS || cmdQ == CMD_REF || cmdQ == CMD_SELF));

endmodule

// File: rtl/sdmon_slot.sv
module sdmon_slot
  import sdmon_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int T_RCD = 3,
  parameter int T_RAS = 5,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             sel,
  input  logic             actEn,
  input  logic             accEn,
  input  logic             apReq,
  input  logic             preHit,
  input  logic [ROW_W-1:0] row,
  input  logic [3:0]       burstLen,
  output bank_e            st,
  output logic [ROW_W-1:0] rowQ,
  output logic             vTim,
  output logic             vSeq,
  output logic             vAp
);

  localparam int AGE_MAX = (T_RAS > T_RCD) ? T_RAS : T_RCD;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam int REM_W   = $clog2(T_RP + 1);
  localparam logic [AGE_W-1:0] RCD_L = AGE_W'(T_RCD);
  localparam logic [AGE_W-1:0] RAS_L = AGE_W'(T_RAS);
  localparam logic [AGE_W-1:0] MAX_L = AGE_W'(AGE_MAX);

  logic [AGE_W-1:0] age;
  logic [REM_W-1:0] rem;
  logic [3:0]       apCnt;
  logic             apPend;
  logic             opened;

  assign opened = (st == BK_OPENING) || (st == BK_OPEN);

  always_comb begin
    vTim = 1'b0;
    vSeq = 1'b0;
    vAp  = 1'b0;
    if (tick) begin
      if (sel && actEn && st != BK_IDLE) vSeq = 1'b1;
      if (sel && accEn) begin
        if (st == BK_IDLE || st == BK_CLOSING) vSeq = 1'b1;
        else if (st == BK_OPENING)             vTim = 1'b1;
        else if (apPend)                       vAp  = 1'b1;
      end
      if (preHit && opened && age < RAS_L) vTim = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= BK_IDLE;
      age    <= '0;
      rem    <= '0;
      apCnt  <= '0;
      apPend <= 1'b0;
      rowQ   <= '0;
    end else if (tick) begin
      if (age < MAX_L) age <= age + AGE_W'(1);
      if (sel && actEn && st == BK_IDLE) begin
        st     <= (T_RCD <= 1) ? BK_OPEN : BK_OPENING;
        age    <= AGE_W'(1);
        rowQ   <= row;
        apPend <= 1'b0;
      end else if (opened && (preHit || (apPend && apCnt == 4'd1))) begin
        st     <= BK_CLOSING;
        rem    <= REM_W'(T_RP - 1);
        apPend <= 1'b0;
      end else begin
        if (st == BK_OPENING && (age + AGE_W'(1)) >= RCD_L) st <= BK_OPEN;
        if (st == BK_CLOSING) begin
          if (rem <= REM_W'(1)) st <= BK_IDLE;
          else                  rem <= rem - REM_W'(1);
        end
        if (sel && accEn && apReq && st == BK_OPEN && !apPend) begin
          apPend <= 1'b1;
          apCnt  <= burstLen;
        end else if (apPend) begin
          apCnt <= apCnt - 4'd1;
        end
      end
    end
  end

  // R8: a pending self-close only exists on an open bank
  a_r8_ap_on_open: assert property (@(posedge clk) disable iff (!rstN)
    apPend |-> (st == BK_OPEN));

  // R6: a bank becomes closed only out of the closing state
  a_r6_idle_from_closing: assert property (@(posedge clk) disable iff (!rstN)
    (st == BK_IDLE && $past(st) != BK_IDLE) |-> ($past(st) == BK_CLOSING));

  // R5: a bank becomes open only out of opening (or closed when T_RCD is 1)
  a_r5_open_from_opening: assert property (@(posedge clk) disable iff (!rstN)
    (st == BK_OPEN && $past(st) != BK_OPEN) |-> ($past(st) == BK_OPENING || $past(st) == BK_IDLE));

  // R13: no state change on a suppressed edge
  a_r13_frozen_state: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(st));

endmodule

// File: rtl/sdmon_banks.sv
module sdmon_banks
  import sdmon_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobe,
  input  logic [ROW_W-1:0]           row,
  output logic [2*NUM_BANKS-1:0]     bankState,
  output logic [ROW_W*NUM_BANKS-1:0] openRow,
  output logic                       allIdle,
  output logic [V_W-1:0]             bankViol
);

  bank_e                stV [NUM_BANKS];
  logic [NUM_BANKS-1:0] vTimV, vSeqV, vApV;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic selI;
    assign selI = (strobe.bank == BANK_W'(i));

    sdmon_slot #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)
    ) u_slot (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (strobe.tick),
      .sel      (selI),
      .actEn    (strobe.act),
      .accEn    (strobe.acc),
      .apReq    (strobe.apReq),
      .preHit   (strobe.pre && (strobe.preAll || selI)),
      .row      (row),
      .burstLen (strobe.burstLen),
      .st       (stV[i]),
      .rowQ     (openRow[ROW_W*i +: ROW_W]),
      .vTim     (vTimV[i]),
      .vSeq     (vSeqV[i]),
      .vAp      (vApV[i])
    );

    assign bankState[2*i +: 2] = stV[i];
  end

  always_comb begin
    allIdle = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (stV[i] != BK_IDLE) allIdle = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankViol <= '0;
    end else begin
      bankViol          <= '0;
      bankViol[V_TIME]  <= |vTimV;
      bankViol[V_SEQ]   <= |vSeqV;
      bankViol[V_APHIT] <= |vApV;
    end
  end

  // R7: a sequence error comes from at most one bank at a time
  a_r7_single_seq: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vSeqV));

endmodule

// File: rtl/sdmon_top.sv
module sdmon_top
  import sdmon_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cke,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [ROW_W-1:0]           addr,
  input  logic [BANK_W-1:0]          ba,
  output logic [3:0]                 cmdCode,
  output logic [2*NUM_BANKS-1:0]     bankState,
  output logic [ROW_W*NUM_BANKS-1:0] openRow,
  output logic [V_W-1:0]             violation
);

  strobe_t        strobe;
  cmd_e           cmdQ;
  logic           allIdle;
  logic [V_W-1:0] ctrlViol, bankViol;

  sdmon_ctrl #(.T_RRD(T_RRD)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .apBit    (addr[AP_BIT]),
    .modeBits (addr[2:0]),
    .ba       (ba),
    .allIdle  (allIdle),
    .strobe   (strobe),
    .cmdQ     (cmdQ),
    .ctrlViol (ctrlViol)
  );

  sdmon_banks #(
    .ROW_W(ROW_W), .NUM_BANKS(NUM_BANKS),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_banks (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .row       (addr),
    .bankState (bankState),
    .openRow   (openRow),
    .allIdle   (allIdle),
    .bankViol  (bankViol)
  );

  assign cmdCode   = cmdQ;
  assign violation = ctrlViol | bankViol;

endmodule

// File: tb/sdmon_top_tb.sv
module sdmon_top_tb;

  localparam int ROW_W = 12;
  localparam int NB    = 4;

  localparam int C_NOP = 0, C_DESEL = 1, C_ACT = 2, C_RD = 3, C_RDA = 4, C_WR = 5, C_WRA = 6,
                 C_BST = 7, C_PRE = 8, C_PREALL = 9, C_REF = 10, C_SELF = 11, C_MRS = 12,
                 C_HOLD = 13;

  logic clk = 1'b0;
  logic rstN, cke, csN, rasN, casN, weN;
  logic [ROW_W-1:0]    addr;
  logic [1:0]          ba;
  logic [3:0]          cmdCode;
  logic [2*NB-1:0]     bankState;
  logic [ROW_W*NB-1:0] openRow;
  logic [5:0]          violation;

  int nChk = 0, nFail = 0, cycles = 0;
  bit prevCke;

  always #10 clk = ~clk;  // 50 MHz

  sdmon_top u_dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .ba(ba), .cmdCode(cmdCode), .bankState(bankState), .openRow(openRow),
    .violation(violation)
  );

  task automatic check(input string tag, input int actual, input int expected);
    nChk++;
    if (actual != expected) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expected);
    end
  endtask

  function automatic int stOf(int i);
    return int'(bankState[2*i +: 2]);
  endfunction

  function automatic int rowOf(int i);
    return int'(openRow[ROW_W*i +: ROW_W]);
  endfunction

  function automatic int expCode(bit pc, bit c, bit s, bit r, bit ca, bit w, bit a10);
    if (!pc) return C_HOLD;
    if (s) return C_DESEL;
    case ({r, ca, w})
      3'b111: return C_NOP;
      3'b011: return C_ACT;
      3'b101: return a10 ? C_RDA : C_RD;
      3'b100: return a10 ? C_WRA : C_WR;
      3'b110: return C_BST;
      3'b010: return a10 ? C_PREALL : C_PRE;
      3'b001: return c ? C_REF : C_SELF;
      default: return C_MRS;
    endcase
  endfunction

  // drive one command at a falling edge, return at the next falling edge
  task automatic issue(input int code, input int bank = 0, input int adr = 0, input bit ckeV = 1'b1);
    logic [ROW_W-1:0] a;
    a = ROW_W'(adr);
    csN = 1'b0; cke = ckeV; ba = 2'(bank);
    case (code)
      C_DESEL:  begin csN = 1'b1; {rasN, casN, weN} = 3'b111; end
      C_ACT:    {rasN, casN, weN} = 3'b011;
      C_RD:     begin {rasN, casN, weN} = 3'b101; a[10] = 1'b0; end
      C_RDA:    begin {rasN, casN, weN} = 3'b101; a[10] = 1'b1; end
      C_WR:     begin {rasN, casN, weN} = 3'b100; a[10] = 1'b0; end
      C_WRA:    begin {rasN, casN, weN} = 3'b100; a[10] = 1'b1; end
      C_BST:    {rasN, casN, weN} = 3'b110;
      C_PRE:    begin {rasN, casN, weN} = 3'b010; a[10] = 1'b0; end
      C_PREALL: begin {rasN, casN, weN} = 3'b010; a[10] = 1'b1; end
      C_REF:    {rasN, casN, weN} = 3'b001;
      C_SELF:   begin {rasN, casN, weN} = 3'b001; cke = 1'b0; end
      C_MRS:    {rasN, casN, weN} = 3'b000;
      default:  {rasN, casN, weN} = 3'b111;
    endcase
    addr = a;
    @(negedge clk);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(C_NOP);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; cke = 1'b1; csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    addr = '0; ba = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 cmd", cmdCode, C_NOP);
    check("R1 banks", bankState, 0);
    check("R1 rows", (openRow == '0) ? 1 : 0, 1);
    check("R1 viol", violation, 0);

    issue(C_MRS, 0, 12'h003);                       // R9 burst 8
    check("R2 mrs code", cmdCode, C_MRS);
    check("R9 mrs legal", violation, 0);
    issue(C_ACT, 0, 12'h123);
    check("R2 act code", cmdCode, C_ACT);
    check("R5 opening", stOf(0), 1);
    check("R4 row0", rowOf(0), 12'h123);
    issue(C_RD, 0);
    check("R5 early read", violation, 6'b000001);
    issue(C_NOP);
    issue(C_RD, 0);
    check("R5 read at T_RCD", violation, 0);
    check("R5 open", stOf(0), 2);
    issue(C_ACT, 1, 12'h010);
    check("R12 spaced act", violation, 0);
    issue(C_ACT, 2, 12'h020);
    check("R12 close act", violation, 6'b000010);
    check("R4 bank2 sel", stOf(2), 1);
    issue(C_ACT, 1, 12'h777);
    check("R7 act busy bank", violation, 6'b000110);
    check("R7 row kept", rowOf(1), 12'h010);
    issue(C_PRE, 0);
    check("R6 legal pre", violation, 0);
    check("R6 closing", stOf(0), 3);
    issue(C_PRE, 2);
    check("R6 early pre", violation, 6'b000001);
    issue(C_ACT, 0, 12'h0AB);
    check("R6 act while closing", violation, 6'b000100);
    check("R6 idle after T_RP", stOf(0), 0);
    issue(C_ACT, 0, 12'h0AB);
    check("R6 act after T_RP", violation, 0);
    check("R4 row0 new", rowOf(0), 12'h0AB);

    issue(C_RDA, 1);
    check("R3 rda code", cmdCode, C_RDA);
    check("R8 rda legal", violation, 0);
    issue(C_NOP);
    issue(C_RD, 1);
    check("R8 same bank hit", violation, 6'b001000);
    issue(C_WR, 0);
    check("R2 wr code", cmdCode, C_WR);
    check("R8 other bank ok", violation, 0);
    nops(4);
    check("R8 still open", stOf(1), 2);
    issue(C_NOP);
    check("R8 closing at BL", stOf(1), 3);
    issue(C_NOP);
    check("R8 closing hold", stOf(1), 3);
    issue(C_NOP);
    check("R8 closed", stOf(1), 0);

    issue(C_MRS, 0, 12'h000);
    check("R10 mrs busy", violation, 6'b010000);
    issue(C_REF);
    check("R10 ref busy", violation, 6'b010000);
    check("R2 ref code", cmdCode, C_REF);
    issue(C_PREALL, 3);
    check("R3 preall code", cmdCode, C_PREALL);
    check("R3 preall legal", violation, 0);
    check("R3 preall banks", bankState, 8'h03);
    nops(2);
    check("R6 all closed", bankState, 0);
    issue(C_REF);
    check("R10 ref idle", violation, 0);

    issue(C_ACT, 3, 12'h3FF);
    check("R4 row3", rowOf(3), 12'h3FF);
    nops(4);
    issue(C_PRE, 3);
    check("R6 pre at T_RAS", violation, 0);
    check("R6 bank3 closing", bankState, 8'hC0);
    issue(C_NOP, 0, 0, 1'b0);
    check("R13 decode with cke low", cmdCode, C_NOP);
    issue(C_NOP, 0, 0, 1'b0);
    issue(C_ACT, 3, 12'h111, 1'b0);
    issue(C_NOP, 0, 0, 1'b0);
    check("R13 hold code", cmdCode, C_HOLD);
    check("R13 no viol", violation, 0);
    check("R13 frozen", bankState, 8'hC0);
    issue(C_NOP);
    check("R13 hold after rise", cmdCode, C_HOLD);
    check("R13 still frozen", bankState, 8'hC0);
    issue(C_NOP);
    check("R13 resumed", cmdCode, C_NOP);
    check("R13 closed after resume", bankState, 0);
    check("R13 row unchanged", rowOf(3), 12'h3FF);
    issue(C_SELF);
    check("R13 self code", cmdCode, C_SELF);
    check("R10 self idle", violation, 0);
    issue(C_NOP);
    check("R13 hold after self", cmdCode, C_HOLD);
    issue(C_NOP);

    issue(C_MRS, 0, 12'h007);
    check("R9 full page set", violation, 0);
    issue(C_ACT, 2, 12'h055);
    nops(2);
    issue(C_RDA, 2);
    check("R11 full page ap", violation, 6'b100000);
    issue(C_RD, 2);
    check("R11 no ap armed", violation, 0);
    check("R11 bank open", stOf(2), 2);

    // random decode phase
    void'($urandom(32'd20240611));
    prevCke = 1'b1;
    for (int i = 0; i < 400; i++) begin
      bit c, s, r, ca, w, a10;
      c = ($urandom % 8) != 0;
      s = ($urandom % 5) == 0;
      r = $urandom; ca = $urandom; w = $urandom; a10 = $urandom;
      cke = c; csN = s; rasN = r; casN = ca; weN = w;
      addr = ROW_W'($urandom); addr[10] = a10; ba = 2'($urandom);
      @(negedge clk);
      check("R2 random decode", cmdCode, expCode(prevCke, c, s, r, ca, w, a10));
      prevCke = c;
    end
    finishRun();
  end

endmodule